// File: doc/BRIEF.md
# Luma Noise-Level Classifier

This block grades incoming luma by how noisy it is, using one line of the vertical blanking interval as the test signal. During that line it adds up the absolute steps between consecutive samples over a fixed window. At the end of the line it compares the total against two programmable bounds and stores one of three quality classes. A downstream motion-adaptive noise filter uses the class to pick its coefficient set and comparator thresholds. Each class caps the noise reduction that the filter may apply.

The class is held for the whole following field. A source-type bit for tape playback fixes the output at the middle class, so that an unstable tape signal does not swing the filter strength. Line and field timing arrive as single-cycle strobes. The measured line, the window length, the sample width and the accumulator width are all parameters.

Top module: `luma_noise_classifier`

## Requirements
- R1: After reset, `quality_class` is 1 (middle class) and stays 1 until the first complete measurement has been committed.
- R2: A `field_start` strobe begins line 1, and each `line_start` without `field_start` begins the next line. A sample that is valid in a strobe cycle belongs to the line that strobe begins. Only samples of line MEAS_LINE (default 6) enter the measurement, and line counting waits for the first `field_start`.
- R3: The noise estimate is the sum of |y[n] - y[n-1]| over the first WINDOW (default 256) valid samples of the measured line, which gives WINDOW-1 differences. Valid samples after the window has filled are ignored.
- R4: The sum is held in an ACC_W-bit accumulator (default 16) that saturates at 2^ACC_W - 1 instead of wrapping.
- R5: Class encoding: 2'd0 = noisy, 2'd1 = middle, 2'd2 = clean. If the sum is greater than `thr_high` the class is 0. Otherwise, if it is less than `thr_low`, the class is 2. Otherwise it is 1. A sum equal to either bound gives class 1, and the noisy test wins when both tests are true.
- R6: The stored class changes only at the strobe (`line_start` or `field_start`) that ends the measured line, and only if the window has filled. A short measured line leaves the stored class unchanged.
- R7: While `vcr_mode` is 1, `quality_class` is 1 in the same cycle. Measurement and commits continue meanwhile, and clearing the bit shows the latest committed class at once.
- R8: `field_start` clears the accumulator and the window count. When it coincides with the end of the measured line, the commit uses the completed sum, and the next field's measurement starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | `luma` carries a sample this cycle |
| luma | input | PIX_W | Luma sample |
| line_start | input | 1 | Single-cycle strobe at the start of each line |
| field_start | input | 1 | Single-cycle strobe at the start of each field |
| thr_low | input | ACC_W | Lower bound: a sum below it is clean |
| thr_high | input | ACC_W | Upper bound: a sum above it is noisy |
| vcr_mode | input | 1 | Tape source: force the middle class |
| quality_class | output | 2 | Current quality class |

## Verification
Two events can fall in the same clock cycle: the commit that ends the measured line and the accumulator clear that a new field brings. The bench provokes this by raising `field_start` and `line_start` together as the strobe that closes a full, noisy measured line. The class seen right after that edge must reflect the noisy sum. A clean field that follows must then classify as clean, which can only happen if the clear took effect and the old sum was not carried into the new measurement.

// File: rtl/lnc_pkg.sv
package lnc_pkg;

   typedef enum logic [1:0] {
      CLS_NOISY = 2'd0,
      CLS_MID   = 2'd1,
      CLS_CLEAN = 2'd2
   } lnc_class_e;

endpackage

// File: rtl/lnc_line_track.sv
module lnc_line_track #(
   parameter int LINE_W    = 10,
   parameter int MEAS_LINE = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic field_start,
   output logic in_meas,
   output logic meas_close
);

   localparam logic [LINE_W-1:0] MEAS_C = LINE_W'(MEAS_LINE);
   localparam logic [LINE_W-1:0] LINE_MAX = '1;
   localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] line_d;

   always_comb begin
      line_d = line_q;
      if (field_start) begin
         line_d = LINE_ONE;
      end else if (line_start && (line_q != '0) && (line_q != LINE_MAX)) begin
         line_d = line_q + LINE_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
      end else begin
         line_q <= line_d;
      end
   end

   // The sample in this cycle belongs to the line that begins now.
   assign in_meas    = (line_d == MEAS_C);
   assign meas_close = (line_start || field_start) && (line_q == MEAS_C);

endmodule

// File: rtl/lnc_sad_accum.sv
module lnc_sad_accum #(
   parameter int PIX_W  = 8,
   parameter int WINDOW = 256,
   parameter int ACC_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample_en,
   input  logic [PIX_W-1:0] luma,
   output logic [ACC_W-1:0] acc,
   output logic             win_full
);

   localparam int CNT_W = $clog2(WINDOW + 1);
   localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WINDOW);
   localparam longint MAX_SUM = longint'(WINDOW - 1) * ((longint'(1) << PIX_W) - 1);
   localparam int SUM_W = $clog2(MAX_SUM + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [PIX_W-1:0] prev_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_add;
   logic [PIX_W-1:0] step;
   logic             take;

   assign take = sample_en && (cnt_q < WIN_C);
   assign step = (luma > prev_q) ? (luma - prev_q) : (prev_q - luma);

   generate
      if (ACC_W >= SUM_W) begin : g_plain
         // The largest possible sum fits, so no saturation logic is needed.
         assign acc_add = acc_q + ACC_W'(step);
      end else begin : g_sat
         logic [ACC_W:0] wide;
         assign wide    = {1'b0, acc_q} + (ACC_W + 1)'(step);
         assign acc_add = wide[ACC_W] ? '1 : wide[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prev_q <= '0;
         acc_q  <= '0;
      end else if (clear) begin
         cnt_q  <= '0;
         acc_q  <= '0;
      end else if (take) begin
         cnt_q  <= cnt_q + CNT_W'(1);
         prev_q <= luma;
         if (cnt_q != '0) begin
            acc_q <= acc_add;
         end
      end
   end

   assign acc      = acc_q;
   assign win_full = (cnt_q == WIN_C);

endmodule

// File: rtl/lnc_class_decide.sv
module lnc_class_decide #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] thr_low,
   input  logic [ACC_W-1:0] thr_high,
   input  logic             vcr_mode,
   output logic [1:0]       class_out
);
   import lnc_pkg::*;

   lnc_class_e cls_q;
   lnc_class_e cls_d;

   always_comb begin
      if (acc > thr_high) begin
         cls_d = CLS_NOISY;
      end else if (acc < thr_low) begin
         cls_d = CLS_CLEAN;
      end else begin
         cls_d = CLS_MID;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q <= CLS_MID;
      end else if (commit) begin
         cls_q <= cls_d;
      end
   end

   assign class_out = vcr_mode ? CLS_MID : cls_q;

endmodule

// File: rtl/luma_noise_classifier.sv
module luma_noise_classifier #(
   parameter int PIX_W     = 8,
   parameter int WINDOW    = 256,
   parameter int ACC_W     = 16,
   parameter int LINE_W    = 10,
   parameter int MEAS_LINE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] luma,
   input  logic             line_start,
   input  logic             field_start,
   input  logic [ACC_W-1:0] thr_low,
   input  logic [ACC_W-1:0] thr_high,
   input  logic             vcr_mode,
   output logic [1:0]       quality_class
);

   generate
      if (WINDOW < 2) begin : g_err_window
         $error("WINDOW must be at least 2");
      end
      if (ACC_W < PIX_W) begin : g_err_acc
         $error("ACC_W must not be narrower than PIX_W");
      end
      if (MEAS_LINE < 2 || MEAS_LINE >= (1 << LINE_W) - 1) begin : g_err_line
         $error("MEAS_LINE must lie in 2 .. 2**LINE_W-2");
      end
   endgenerate

   logic             in_meas;
   logic             meas_close;
   logic [ACC_W-1:0] acc;
   logic             win_full;

   lnc_line_track #(
      .LINE_W    (LINE_W),
      .MEAS_LINE (MEAS_LINE)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_start  (line_start),
      .field_start (field_start),
      .in_meas     (in_meas),
      .meas_close  (meas_close)
   );

   lnc_sad_accum #(
      .PIX_W  (PIX_W),
      .WINDOW (WINDOW),
      .ACC_W  (ACC_W)
   ) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (field_start),
      .sample_en (pix_valid && in_meas),
      .luma      (luma),
      .acc       (acc),
      .win_full  (win_full)
   );

   lnc_class_decide #(
      .ACC_W (ACC_W)
   ) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (meas_close && win_full),
      .acc       (acc),
      .thr_low   (thr_low),
      .thr_high  (thr_high),
      .vcr_mode  (vcr_mode),
      .class_out (quality_class)
   );

endmodule

// File: rtl/lnc_checker.sv
module lnc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       line_start,
   input logic       field_start,
   input logic       vcr_mode,
   input logic [1:0] quality_class
);

   logic seen_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_strobe <= 1'b0;
      end else if (line_start || field_start) begin
         seen_strobe <= 1'b1;
      end
   end

   p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      quality_class != 2'd3);

   p_tape_forces_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vcr_mode |-> (quality_class == 2'd1));

   p_hold_between_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_start && !field_start) |=>
         ((vcr_mode != $past(vcr_mode)) || $stable(quality_class)));

   p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_strobe |-> (quality_class == 2'd1));

endmodule

bind luma_noise_classifier lnc_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .line_start    (line_start),
   .field_start   (field_start),
   .vcr_mode      (vcr_mode),
   .quality_class (quality_class)
);

// File: tb/sim_luma_noise_classifier.sv
`timescale 1ns/1ps
module sim_luma_noise_classifier;

   localparam int NV = 8;
   // Alternating sample pair a/b gives a sum of 255*|a-b|.
   localparam int VA  [NV] = '{100,   0,    0,    0,    0,     0,    0,   50};
   localparam int VB  [NV] = '{100,  10,    2,    2,    2,   255,    2,   60};
   localparam int VLO [NV] = '{ 10, 100,  100,  510,  100,     0, 1000,  100};
   localparam int VHI [NV] = '{1000,1000, 1000, 1000,  510, 65535,  100, 2549};
   localparam int VEX [NV] = '{  2,   0,    1,    1,    1,     1,    0,    0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic [7:0]  luma = '0;
   logic        line_start = 1'b0;
   logic        field_start = 1'b0;
   logic [15:0] thr_low = '0;
   logic [15:0] thr_high = '0;
   logic [11:0] thr_low1 = '0;
   logic [11:0] thr_high1 = '0;
   logic        vcr_mode = 1'b0;
   logic [1:0]  quality_class;
   logic [1:0]  quality_class1;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   int prev = 1;

   always #2.5 clk = ~clk;

   luma_noise_classifier u0 (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .luma(luma),
      .line_start(line_start), .field_start(field_start),
      .thr_low(thr_low), .thr_high(thr_high), .vcr_mode(vcr_mode),
      .quality_class(quality_class)
   );

   luma_noise_classifier #(.ACC_W(12)) u1 (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .luma(luma),
      .line_start(line_start), .field_start(field_start),
      .thr_low(thr_low1), .thr_high(thr_high1), .vcr_mode(vcr_mode),
      .quality_class(quality_class1)
   );

   task automatic check(input string tag, input int got, input int exp);
      nchk++;
      if (got != exp) begin
         nerr++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic strobe(input bit fs);
      @(negedge clk);
      pix_valid = 1'b0; line_start = 1'b1; field_start = fs;
      @(negedge clk);
      line_start = 1'b0; field_start = 1'b0;
   endtask

   task automatic sample(input int v);
      @(negedge clk);
      pix_valid = 1'b1; luma = 8'(v);
   endtask

   task automatic noise(input int k);
      for (int i = 0; i < k; i++) sample((i % 2 == 0) ? 0 : 255);
      @(negedge clk);
      pix_valid = 1'b0;
   endtask

   // One field: lines 1..5 carry noise (R2), line 6 carries n alternating
   // a/b samples plus noise past the window (R3), then the closing strobe.
   task automatic run_field(input int a, input int b, input int n,
                            input bit close_fs, input int hold_exp);
      strobe(1'b1); noise(3);
      for (int l = 2; l <= 5; l++) begin strobe(1'b0); noise(3); end
      strobe(1'b0);
      for (int i = 0; i < n; i++) sample((i % 2 == 0) ? a : b);
      if (n >= 256) noise(4);
      @(negedge clk);
      pix_valid = 1'b0;
      check("R6 hold before close", quality_class, hold_exp);
      strobe(close_fs);
   endtask

   initial begin
      thr_low = 16'd10; thr_high = 16'd1000;
      repeat (3) @(negedge clk);
      check("R1 reset class", quality_class, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", quality_class, 1);

      // Short measured line right after reset: nothing committed.
      run_field(100, 100, 100, 1'b0, 1);
      check("R1 short first line keeps mid", quality_class, 1);
      noise(3);

      for (int v = 0; v < NV; v++) begin
         thr_low = 16'(VLO[v]); thr_high = 16'(VHI[v]);
         run_field(VA[v], VB[v], 256, 1'b0, prev);
         check($sformatf("R5 R2 R3 vector %0d", v), quality_class, VEX[v]);
         prev = VEX[v];
         noise(3);
      end

      // Short line after a valid class: stays (prev = 0).
      thr_low = 16'd100; thr_high = 16'd1000;
      run_field(100, 100, 255, 1'b0, prev);
      check("R6 short line no update", quality_class, prev);

      // Tape mode: clean measurement, output held at mid.
      vcr_mode = 1'b1;
      run_field(100, 100, 256, 1'b0, 1);
      check("R7 tape forces mid", quality_class, 1);
      @(negedge clk);
      vcr_mode = 1'b0;
      #0.5;
      check("R7 release shows measured", quality_class, 2);

      // Commit coinciding with field start, then clean field.
      run_field(0, 10, 256, 1'b1, 2);
      check("R8 commit at field start", quality_class, 0);
      run_field(100, 100, 256, 1'b0, 0);
      check("R8 clear gives clean", quality_class, 2);

      // Saturation on the 12-bit instance.
      thr_low1 = 12'd0; thr_high1 = 12'd4094;
      run_field(0, 255, 256, 1'b0, 2);
      check("R4 saturated above 4094", quality_class1, 0);
      thr_high1 = 12'd4095;
      run_field(0, 255, 256, 1'b0, 0);
      check("R4 saturated equals 4095", quality_class1, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog got=hung exp=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule